// File: doc/BRIEF.md
# Programmable Clock-Output Divider

This block drives a clock-output pin from the core clock `f`. An 8-bit control register sets the pin rate. The pin can carry `f` itself, or the half-rate phase clock `f/2` divided by 1, 2, 4 or 8. That gives five rates: f, f/2, f/4, f/8 and f/16. Every divided rate comes from one free-running counter clocked by `f` and has a 50% duty cycle.

Software writes the register through a one-cycle write strobe with an address match, and reads it back through the same address. The new value can be read back at once. The pin changes to the new setting only at the counter wrap point. At that point every divided tap falls together, so the pin is low and a full half period of the new setting follows. No runt pulse appears on the pin. A change into or out of the undivided mode uses an enable that changes only while `f` is low.

Top module: `clkout_divider`

## Requirements
- R1: After reset the register reads 00h and the pin runs at f/16, a period of 16 clock cycles.
- R2: Register bits 7:3 always read as zero, whatever value was written to them.
- R3: When bit 2 is 1, the pin carries the clock itself, with a period of one cycle. Bits 1:0 have no effect in this mode.
- R4: When bit 2 is 0, bits 1:0 select the period: 00 gives 16 cycles, 01 gives 8, 10 gives 4 and 11 gives 2. Each divided output is high for exactly half its period.
- R5: The read port returns the register value when the address equals the register address, and zero for any other address.
- R6: The register loads the data bits only when the write strobe is high and the address matches in the same cycle. Any other write leaves the register and the pin unchanged.
- R7: A new setting reaches the pin only at the next counter wrap, the cycle in which all divided taps fall together. Until then the old setting keeps driving the pin.
- R8: While the setting changes, no high or low pulse on the pin is shorter than half the period of the faster of the old and new settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock f |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | One-cycle write strobe |
| addr | input | ADDR_W | Register address for writes and reads |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, with the reserved bits held at zero |
| ckOut | output | 1 | Clock-output pin |

## Verification
A register write and the counter wrap that commits a setting can fall in the same cycle. In that case, which setting the pin takes at that wrap depends on the exact cycle of the write. The bench provokes this by writing new settings at every offset from 0 to 15 cycles across the 16-cycle wrap interval, alternating between a slow rate and a fast one. A timing monitor records the shortest high or low interval on the pin over the whole sweep and compares it against half the faster period. A separate test writes just after a known falling edge and checks that the old rate keeps driving the pin until the wrap.

// File: rtl/ckdiv_pkg.sv
`timescale 1ns/1ps
package ckdiv_pkg;
  localparam int DIV_CODE_W = 2;
  localparam int NUM_TAPS   = 1 << DIV_CODE_W;
  localparam int CNT_W      = NUM_TAPS;

  typedef struct packed {
    logic                  bypass;
    logic [DIV_CODE_W-1:0] divCode;
  } ck_sel_t;

  localparam int SEL_W = $bits(ck_sel_t);

  typedef struct packed {
    logic    commit;
    ck_sel_t sel;
  } ck_strobe_t;
endpackage

// File: rtl/clkout_div_ctrl.sv
`timescale 1ns/1ps
module clkout_div_ctrl
  import ckdiv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrapNow,
  output logic [DATA_W-1:0] rdData,
  output ck_strobe_t        strb
);
  localparam int PAD_W = DATA_W - SEL_W;

  ck_sel_t cfgReg;
  ck_sel_t actSel;
  logic    addrHit;

  assign addrHit = (addr == REG_ADDR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (wrEn && addrHit) begin
      cfgReg <= ck_sel_t'(wrData[SEL_W-1:0]);
    end
  end

  // the pending setting is committed only when every divided tap falls together
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actSel <= '0;
    end else if (wrapNow) begin
      actSel <= cfgReg;
    end
  end

  always_comb begin
    rdData = '0;
    if (addrHit) rdData = {{PAD_W{1'b0}}, cfgReg};
  end

  assign strb.commit = wrapNow;
  assign strb.sel    = actSel;

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addrHit) |=> (cfgReg == $past(wrData[SEL_W-1:0]))); // R6
  AST_MISS_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addrHit) |=> $stable(cfgReg)); // R6
  AST_COMMIT_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !wrapNow |=> $stable(actSel)); // R7
endmodule

// File: rtl/clkout_div_dp.sv
`timescale 1ns/1ps
module clkout_div_dp
  import ckdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ck_strobe_t strb,
  output logic       wrapNow,
  output logic       ckOut
);
  logic [CNT_W-1:0]      cnt;
  logic [CNT_W-1:0]      cntNext;
  logic [NUM_TAPS-1:0]   tapVec;
  logic [DIV_CODE_W-1:0] tapIdx;
  logic                  divNext;
  logic                  divOut;
  logic                  fEn;

  assign cntNext = cnt + 1'b1;
  assign wrapNow = (cnt == {CNT_W{1'b1}});

  // tap k carries f/(2^(k+1)); the code counts down from the slowest tap
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    assign tapVec[k] = cntNext[k];
  end

  assign tapIdx  = DIV_CODE_W'(NUM_TAPS - 1) - strb.sel.divCode;
  assign divNext = tapVec[tapIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      divOut <= 1'b0;
    end else begin
      cnt    <= cntNext;
      divOut <= divNext;
    end
  end

  // the bypass enable moves only while clk is low, so the gated clock cannot chop a pulse
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) fEn <= 1'b0;
    else       fEn <= strb.sel.bypass;
  end

  assign ckOut = fEn ? clk : divOut;

  AST_WRAP_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> !divOut); // R8
  AST_DIV_HALF: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.sel.bypass && strb.sel.divCode == '1 && $stable(strb.sel))
      |=> (divOut != $past(divOut))); // R4
endmodule

// File: rtl/clkout_divider.sv
`timescale 1ns/1ps
module clkout_divider
  import ckdiv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              ckOut
);
  ck_strobe_t strb;
  logic       wrapNow;

  clkout_div_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .wrapNow(wrapNow), .rdData(rdData), .strb(strb)
  );

  clkout_div_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrapNow(wrapNow), .ckOut(ckOut)
  );
endmodule

// File: tb/clkout_divider_tb.sv
`timescale 1ns/1ps
module clkout_divider_tb;
  localparam real TCK = 5.0;
  localparam logic [7:0] RADDR = 8'h80;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] addr = RADDR;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       ckOut;

  int  nChk = 0;
  int  nBad = 0;
  bit  trackOn = 1'b0;
  real lastEdge = 0.0;
  real minW = 1.0e9;

  clkout_divider u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .ckOut(ckOut)
  );

  always #(TCK/2) clk = ~clk;

  always @(ckOut) begin
    real w;
    w = $realtime - lastEdge;
    if (trackOn && w > 0.0 && w < minW) minW = w;
    lastEdge = $realtime;
  end

  task automatic chk(input string tag, input real act, input real exp);
    nChk++;
    if (act < exp - 0.01 || act > exp + 0.01) begin
      nBad++;
      $display("FAIL %s actual=%0.3f expected=%0.3f", tag, act, exp);
    end
  endtask

  task automatic chkMin(input string tag, input real act, input real lim);
    nChk++;
    if (act < lim - 0.01) begin
      nBad++;
      $display("FAIL %s actual=%0.3f expected>=%0.3f", tag, act, lim);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = RADDR; wrData = '0;
  endtask

  task automatic rd(input logic [7:0] a, input string tag, input logic [7:0] exp);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, real'(rdData), real'(exp));
    addr = RADDR;
  endtask

  task automatic measure(input string tag, input real expPer);
    real t0, t1, t2;
    repeat (40) @(posedge clk);
    @(posedge ckOut); t0 = $realtime;
    @(negedge ckOut); t1 = $realtime;
    @(posedge ckOut); t2 = $realtime;
    chk({tag, " period"}, t2 - t0, expPer);
    chk({tag, " high"}, t1 - t0, expPer / 2.0);
  endtask

  task automatic testReset();
    rd(RADDR, "R1 reset value", 8'h00);
    measure("R1 reset rate", 16.0 * TCK);
  endtask

  task automatic testRates();
    wr(RADDR, 8'h03); measure("R4 code 11", 2.0 * TCK);
    wr(RADDR, 8'h02); measure("R4 code 10", 4.0 * TCK);
    wr(RADDR, 8'h01); measure("R4 code 01", 8.0 * TCK);
    wr(RADDR, 8'h00); measure("R4 code 00", 16.0 * TCK);
    wr(RADDR, 8'h04); measure("R3 bypass code 00", TCK);
    wr(RADDR, 8'h07); measure("R3 bypass code 11", TCK);
  endtask

  task automatic testReserved();
    wr(RADDR, 8'hF9);
    rd(RADDR, "R2 reserved masked", 8'h01);
    measure("R2 rate after reserved write", 8.0 * TCK);
  endtask

  task automatic testAddr();
    wr(8'h81, 8'h03);
    rd(RADDR, "R6 miss keeps value", 8'h01);
    rd(8'h7F, "R5 other address reads zero", 8'h00);
    measure("R6 rate after miss", 8.0 * TCK);
  endtask

  task automatic testDefer();
    real tf, tr, ta, tb;
    wr(RADDR, 8'h00);
    repeat (40) @(posedge clk);
    @(negedge ckOut); tf = $realtime;
    wr(RADDR, 8'h03);
    @(posedge ckOut); tr = $realtime;
    chk("R7 old rate holds until wrap", tr - tf, 8.0 * TCK);
    @(negedge ckOut);
    @(posedge ckOut); ta = $realtime;
    @(posedge ckOut); tb = $realtime;
    chk("R7 new rate after wrap", tb - ta, 2.0 * TCK);
  endtask

  task automatic sweep(input string tag, input logic [7:0] a, input logic [7:0] b,
                       input real lim);
    wr(RADDR, a);
    repeat (40) @(posedge clk);
    @(posedge ckOut);
    lastEdge = $realtime; minW = 1.0e9; trackOn = 1'b1;
    for (int k = 0; k < 16; k++) begin
      wr(RADDR, (k % 2 == 0) ? b : a);
      repeat (k + 24) @(posedge clk);
    end
    trackOn = 1'b0;
    chkMin(tag, minW, lim);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testRates();
    testReserved();
    testAddr();
    testDefer();
    sweep("R8 f/16 vs f/2 min pulse", 8'h00, 8'h03, TCK);
    sweep("R8 f/4 vs f min pulse", 8'h02, 8'h04, TCK / 2.0);
    sweep("R8 f/16 vs f min pulse", 8'h00, 8'h05, TCK / 2.0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule